// File: doc/BRIEF.md
# Memory-Mapped 16-Pin GPIO Port

This block is one general-purpose I/O port of sixteen pins behind a 32-bit word-access register bus. Software gives each pin a direction mode, a driver style, a slew-rate code, a pull choice and a 4-bit peripheral-function number. The block then produces registered pad-control outputs for every pin: the output value, output enable, open-drain flag, pull-up and pull-down requests, an analog flag and a 2-bit speed code.

Pad inputs pass through a two-flop synchronizer and are stored in an input-level register that software can read. The output-level register can be rewritten as a whole with read-modify-write, or changed bit by bit through a write-only set/clear register without a read. For a pin in peripheral mode, the pad value comes from one of sixteen peripheral signals for that pin, selected by the pin's function number.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset every register reads 0, and every pad output is 0 (all pins are inputs with no pull and no drive).
- R2: Words sit at byte offsets 0x00 mode, 0x04 driver type, 0x08 speed, 0x0C pull, 0x10 input level, 0x14 output level, 0x18 set/clear, 0x20 function number for pins 0-7, 0x24 function number for pins 8-15. The mode, speed, pull and both function-number words store and return all 32 bits. The driver-type word keeps bits 15:0 and reads 0 above them. An access whose address bits 1:0 are not 00 is ignored.
- R3: A write to the output-level word stores bits 15:0. The read value has bits 31:16 at 0.
- R4: A write to the set/clear word sets output bit n when data bit n is 1, and clears output bit n when data bit n+16 is 1. If both are 1 for the same pin, the pin is set. Zero bits leave the pin as it was. This word reads as 0.
- R5: The input-level word returns the pad levels after a two-flop synchronizer, in bits 15:0. Pins in analog mode read 0. Writes to this word have no effect.
- R6: The mode field of pin p is at bits 2p+1:2p: 0 input, 1 output, 2 peripheral, 3 analog. Output enable can be 1 only in mode 1 or 2.
- R7: The driver-type bit p is 0 for push-pull and 1 for open-drain. When it is 1, the pad is enabled only while the pin's output value is 0. The open-drain flag output copies this bit.
- R8: The pull field of pin p is at bits 2p+1:2p: 1 requests pull-up, 2 requests pull-down, and 0 or 3 requests neither. The analog flag is 1 exactly for pins in mode 3.
- R9: The speed output carries the pin's 2-bit speed code (0 low to 3 high) at the same bit positions as the speed word.
- R10: In mode 2 the output value of pin p is peripheral signal number F of that pin, where F is the 4-bit field at bits 4(p mod 8)+3:4(p mod 8) of the low word for p<8 and of the high word for p≥8. Peripheral signal F of pin p is input bit 16p+F. In mode 1 the output value is the output-level bit.
- R11: Read data appears on the read-data port on the clock edge after the read strobe. Pad outputs follow a register or peripheral-signal change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Raw pad input levels |
| periph_sig | input | 256 | Peripheral signals, 16 per pin, pin p at bits 16p+15:16p |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Output enable per pin |
| pad_od | output | 16 | Open-drain flag per pin |
| pad_pu | output | 16 | Pull-up request per pin |
| pad_pd | output | 16 | Pull-down request per pin |
| pad_ana | output | 16 | Analog flag per pin |
| pad_speed | output | 32 | Speed code, 2 bits per pin |

## Verification
The set/clear path is run through a table of eight writes. These cover set only, clear only, the same pin asked to set and clear at once, an all-zero write, a clear of every pin, and mixed set and clear on different pins. After each write the output word is read back, so lost or inverted halves show up, as does the wrong priority on a conflict. Peripheral routing puts one pin in each function word and drives one selected and one unselected signal, so an error in the field offset or in the choice between low and high word gives a wrong pad value. Open-drain and push-pull are compared with the output bit at both levels. Analog and non-analog pins get the same pad level, so the analog masking of the input word can be told apart from the synchronizer.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_PERIPH = 2'd2,
    PM_ANALOG = 2'd3
  } pin_mode_e;

  typedef enum logic [3:0] {
    WD_MODE   = 4'd0,
    WD_DRV    = 4'd1,
    WD_SPEED  = 4'd2,
    WD_PULL   = 4'd3,
    WD_INLVL  = 4'd4,
    WD_OUTLVL = 4'd5,
    WD_SETCLR = 4'd6,
    WD_FNLO   = 4'd8,
    WD_FNHI   = 4'd9
  } reg_word_e;

  localparam logic [1:0] PULL_UP_CODE   = 2'd1;
  localparam logic [1:0] PULL_DOWN_CODE = 2'd2;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int MODE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        in_sync,
  output logic [NUM_PINS*MODE_W-1:0] mode_q,
  output logic [NUM_PINS-1:0]        drv_q,
  output logic [NUM_PINS*2-1:0]      speed_q,
  output logic [NUM_PINS*2-1:0]      pull_q,
  output logic [NUM_PINS-1:0]        outlvl_q,
  output logic [DATA_W-1:0]          fnlo_q,
  output logic [DATA_W-1:0]          fnhi_q
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word_idx;
  logic                aligned;
  logic                wr_hit;
  logic                rd_hit;
  logic [NUM_PINS-1:0] inlvl_q;
  logic [NUM_PINS-1:0] ana_mask;
  logic [DATA_W-1:0]   rd_mux;
  logic                wr_setclr;

  assign word_idx  = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign wr_hit    = bus_wr && aligned;
  assign rd_hit    = bus_rd && aligned;
  assign wr_setclr = wr_hit && (word_idx == WORD_W'(WD_SETCLR));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ana
    assign ana_mask[p] = (mode_q[p*MODE_W +: MODE_W] == PM_ANALOG);
  end

  always_ff @(posedge clk) begin
    if (rst) inlvl_q <= '0;
    else     inlvl_q <= in_sync & ~ana_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      drv_q    <= '0;
      speed_q  <= '0;
      pull_q   <= '0;
      outlvl_q <= '0;
      fnlo_q   <= '0;
      fnhi_q   <= '0;
    end else if (wr_hit) begin
      case (word_idx)
        WORD_W'(WD_MODE):   mode_q   <= bus_wdata[NUM_PINS*MODE_W-1:0];
        WORD_W'(WD_DRV):    drv_q    <= bus_wdata[NUM_PINS-1:0];
        WORD_W'(WD_SPEED):  speed_q  <= bus_wdata[NUM_PINS*2-1:0];
        WORD_W'(WD_PULL):   pull_q   <= bus_wdata[NUM_PINS*2-1:0];
        WORD_W'(WD_OUTLVL): outlvl_q <= bus_wdata[NUM_PINS-1:0];
        WORD_W'(WD_SETCLR): outlvl_q <= (outlvl_q & ~bus_wdata[2*NUM_PINS-1:NUM_PINS])
                                        | bus_wdata[NUM_PINS-1:0];
        WORD_W'(WD_FNLO):   fnlo_q   <= bus_wdata;
        WORD_W'(WD_FNHI):   fnhi_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (word_idx)
      WORD_W'(WD_MODE):   rd_mux = DATA_W'(mode_q);
      WORD_W'(WD_DRV):    rd_mux = DATA_W'(drv_q);
      WORD_W'(WD_SPEED):  rd_mux = DATA_W'(speed_q);
      WORD_W'(WD_PULL):   rd_mux = DATA_W'(pull_q);
      WORD_W'(WD_INLVL):  rd_mux = DATA_W'(inlvl_q);
      WORD_W'(WD_OUTLVL): rd_mux = DATA_W'(outlvl_q);
      WORD_W'(WD_FNLO):   rd_mux = fnlo_q;
      WORD_W'(WD_FNHI):   rd_mux = fnhi_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= rd_mux;
  end

  // R4: every requested set lands on the output level
  a_r4_set_applied: assert property (@(posedge clk) disable iff (rst)
    wr_setclr |=> ((outlvl_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

  // R4: a clear without a matching set leaves the bit at 0
  a_r4_clear_applied: assert property (@(posedge clk) disable iff (rst)
    wr_setclr |=> ((outlvl_q & $past(bus_wdata[2*NUM_PINS-1:NUM_PINS])
                    & ~$past(bus_wdata[NUM_PINS-1:0])) == '0));

  // R5: analog pins never show a level in the input word
  a_r5_analog_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ((inlvl_q & $past(ana_mask)) == '0));

  // R1: reset leaves the output level and the modes cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (outlvl_q == '0 && mode_q == '0));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter int FN_W   = 4,
  localparam int NUM_FN = 1 << FN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              drv_od,
  input  logic [1:0]        speed,
  input  logic [1:0]        pull,
  input  logic [FN_W-1:0]   fn_sel,
  input  logic              out_lvl,
  input  logic [NUM_FN-1:0] periph,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_od,
  output logic              pad_pu,
  output logic              pad_pd,
  output logic              pad_ana,
  output logic [1:0]        pad_speed
);
  logic drive_mode;
  logic val_d;
  logic oe_d;

  assign drive_mode = (mode == PM_OUTPUT) || (mode == PM_PERIPH);
  assign val_d      = (mode == PM_PERIPH) ? periph[fn_sel] : out_lvl;
  assign oe_d       = drive_mode && (!drv_od || !val_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out   <= 1'b0;
      pad_oe    <= 1'b0;
      pad_od    <= 1'b0;
      pad_pu    <= 1'b0;
      pad_pd    <= 1'b0;
      pad_ana   <= 1'b0;
      pad_speed <= '0;
    end else begin
      pad_out   <= val_d;
      pad_oe    <= oe_d;
      pad_od    <= drv_od;
      pad_pu    <= (pull == PULL_UP_CODE);
      pad_pd    <= (pull == PULL_DOWN_CODE);
      pad_ana   <= (mode == PM_ANALOG);
      pad_speed <= speed;
    end
  end

  // R6: enable only follows an output or peripheral mode
  a_r6_oe_needs_drive_mode: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> ($past(mode) == PM_OUTPUT || $past(mode) == PM_PERIPH));

  // R7: an open-drain pad is only driven low
  a_r7_od_drives_low_only: assert property (@(posedge clk) disable iff (rst)
    (pad_oe && pad_od) |-> !pad_out);

  // R8: never both pulls at once
  a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pad_pu, pad_pd}));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int FN_W        = 4,
  localparam int MODE_W     = 2,
  localparam int NUM_FN     = 1 << FN_W,
  localparam int FN_PER_WD  = DATA_W / FN_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  input  logic [NUM_PINS*NUM_FN-1:0] periph_sig,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS-1:0]        pad_od,
  output logic [NUM_PINS-1:0]        pad_pu,
  output logic [NUM_PINS-1:0]        pad_pd,
  output logic [NUM_PINS-1:0]        pad_ana,
  output logic [NUM_PINS*2-1:0]      pad_speed
);
  logic [NUM_PINS-1:0]        in_sync;
  logic [NUM_PINS*MODE_W-1:0] mode_q;
  logic [NUM_PINS-1:0]        drv_q;
  logic [NUM_PINS*2-1:0]      speed_q;
  logic [NUM_PINS*2-1:0]      pull_q;
  logic [NUM_PINS-1:0]        outlvl_q;
  logic [DATA_W-1:0]          fnlo_q;
  logic [DATA_W-1:0]          fnhi_q;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pad_in), .q_sync(in_sync)
  );

  gpio_reg_file #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_sync(in_sync), .mode_q(mode_q), .drv_q(drv_q), .speed_q(speed_q),
    .pull_q(pull_q), .outlvl_q(outlvl_q), .fnlo_q(fnlo_q), .fnhi_q(fnhi_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int FN_OFS = (p % FN_PER_WD) * FN_W;
    logic [FN_W-1:0] fn_sel;

    if (p < FN_PER_WD) begin : g_lo
      assign fn_sel = fnlo_q[FN_OFS +: FN_W];
    end else begin : g_hi
      assign fn_sel = fnhi_q[FN_OFS +: FN_W];
    end

    gpio_pin_ctrl #(.MODE_W(MODE_W), .FN_W(FN_W)) u_pin (
      .clk(clk), .rst(rst),
      .mode(mode_q[p*MODE_W +: MODE_W]),
      .drv_od(drv_q[p]),
      .speed(speed_q[p*2 +: 2]),
      .pull(pull_q[p*2 +: 2]),
      .fn_sel(fn_sel),
      .out_lvl(outlvl_q[p]),
      .periph(periph_sig[p*NUM_FN +: NUM_FN]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p]), .pad_od(pad_od[p]),
      .pad_pu(pad_pu[p]), .pad_pd(pad_pd[p]), .pad_ana(pad_ana[p]),
      .pad_speed(pad_speed[p*2 +: 2])
    );
  end

endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [15:0]  pad_in = '0;
  logic [255:0] periph_sig = '0;
  logic [15:0]  pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ana;
  logic [31:0]  pad_speed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [5:0] A_MODE = 6'h00, A_DRV = 6'h04, A_SPEED = 6'h08,
    A_PULL = 6'h0C, A_IN = 6'h10, A_OUT = 6'h14, A_SC = 6'h18,
    A_FNLO = 6'h20, A_FNHI = 6'h24;

  // {set/clear write data, expected output word afterwards}, start at 0x00F0
  localparam logic [63:0] SC_VEC [8] = '{
    {32'h0000_0003, 32'h0000_00F3},
    {32'h0030_0000, 32'h0000_00C3},
    {32'h0001_0000, 32'h0000_00C2},
    {32'h0001_0001, 32'h0000_00C3},
    {32'h0000_0000, 32'h0000_00C3},
    {32'hFFFF_0000, 32'h0000_0000},
    {32'h0000_8000, 32'h0000_8000},
    {32'h8000_0100, 32'h0000_0100}
  };

  gpio_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .periph_sig(periph_sig), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_ana(pad_ana), .pad_speed(pad_speed)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [5:0] addrs [9] = '{A_MODE, A_DRV, A_SPEED, A_PULL, A_IN, A_OUT, A_SC, A_FNLO, A_FNHI};
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    for (int i = 0; i < 9; i++) begin
      bus_read(addrs[i], v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 pad_oe reset", {16'h0, pad_oe}, 32'h0);
    check("R1 pulls reset", {pad_pu, pad_pd}, 32'h0);

    // R2: storage widths and misaligned access
    bus_write(A_MODE, 32'hA5A5_1234);
    bus_read(A_MODE, v);  check("R2 mode readback", v, 32'hA5A5_1234);
    bus_write(A_DRV, 32'hFFFF_FFFF);
    bus_read(A_DRV, v);   check("R2 drv upper zero", v, 32'h0000_FFFF);
    bus_write(A_FNHI, 32'h1234_5678);
    bus_read(A_FNHI, v);  check("R2 fnhi readback", v, 32'h1234_5678);
    bus_write(6'h01, 32'h0000_00FF);
    bus_read(A_MODE, v);  check("R2 misaligned ignored", v, 32'hA5A5_1234);
    bus_write(A_DRV, 32'h0);
    bus_write(A_FNHI, 32'h0);

    // R3: output word
    bus_write(A_OUT, 32'hDEAD_00F0);
    bus_read(A_OUT, v);   check("R3 outlvl readback", v, 32'h0000_00F0);
    bus_write(A_MODE, 32'h5555_5555);
    settle();
    check("R3 pad_out output mode", {16'h0, pad_out}, 32'h0000_00F0);
    check("R6 pad_oe output mode", {16'h0, pad_oe}, 32'h0000_FFFF);

    // R4: set/clear vector table
    for (int i = 0; i < 8; i++) begin
      bus_write(A_SC, SC_VEC[i][63:32]);
      bus_read(A_OUT, v);
      check("R4 set/clear step", v, SC_VEC[i][31:0]);
    end
    bus_read(A_SC, v);    check("R4 setclr reads zero", v, 32'h0);

    // R7: open drain on pin 0 (output word now 0x0100, bit 0 low)
    bus_write(A_DRV, 32'h0000_0001);
    settle();
    check("R7 od low drives", {31'h0, pad_oe[0]}, 32'h1);
    check("R7 od flag", {16'h0, pad_od}, 32'h0000_0001);
    bus_write(A_SC, 32'h0000_0001);
    settle();
    check("R7 od high released", {31'h0, pad_oe[0]}, 32'h0);
    check("R7 push-pull pin8 driven", {31'h0, pad_oe[8]}, 32'h1);

    // R5: input sampling, analog masking, write ignored
    bus_write(A_MODE, 32'h0000_0C00);
    pad_in = 16'h0021;
    repeat (5) @(negedge clk);
    bus_read(A_IN, v);    check("R5 input level analog masked", v, 32'h0000_0001);
    check("R8 analog flag", {16'h0, pad_ana}, 32'h0000_0020);
    check("R6 no drive in input/analog", {16'h0, pad_oe}, 32'h0);
    bus_write(A_IN, 32'hFFFF_FFFF);
    bus_read(A_IN, v);    check("R5 input write ignored", v, 32'h0000_0001);

    // R8: pulls, code 3 gives neither
    bus_write(A_PULL, 32'h0000_3240);
    settle();
    check("R8 pull-up", {16'h0, pad_pu}, 32'h0000_0008);
    check("R8 pull-down", {16'h0, pad_pd}, 32'h0000_0010);

    // R9: speed codes
    bus_write(A_SPEED, 32'h0000_00E4);
    settle();
    check("R9 speed codes", pad_speed, 32'h0000_00E4);

    // R10: peripheral routing, pin 2 via low word fn 3, pin 9 via high word fn 5
    bus_write(A_MODE, 32'h0008_0020);
    bus_write(A_FNLO, 32'h0000_0300);
    bus_write(A_FNHI, 32'h0000_0050);
    @(negedge clk);
    periph_sig = '0;
    periph_sig[9*16+5] = 1'b1;
    periph_sig[2*16+4] = 1'b1;
    settle();
    check("R10 periph select A", {16'h0, pad_out & 16'h0204}, 32'h0000_0200);
    check("R10 periph drive enable", {16'h0, pad_oe}, 32'h0000_0204);
    periph_sig = '0;
    periph_sig[9*16+4] = 1'b1;
    periph_sig[2*16+3] = 1'b1;
    @(negedge clk);
    check("R11 periph change one clock", {16'h0, pad_out & 16'h0204}, 32'h0000_0004);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, fails);
    $finish;
  end
endmodule